// File: doc/BRIEF.md
# LED Driver Supervisory State Controller

This block is the operating-state supervisor for a switching LED driver. It receives digitized comparator flags: the supply thresholds, the overvoltage and undervoltage comparators on the output-sense pin, over-temperature, the winding-short comparator, an open-sense fault on the off-time current sense, and a "reference too low" request from thermal foldback. It also takes a per-switching-pulse strobe. From these it decides whether the power switch may switch, and it reports its operating state as a 3-bit code.

Faults come in two kinds. Auto-restart faults (overvoltage, output-sense undervoltage, over-temperature, reference-too-low) hold the block in a stop state. The block leaves that state on its own once each condition has cleared and the supply is above its turn-on level. Latched faults (a run of consecutive winding-short pulses, or an open current-sense pin) hold the block off until the supply collapses below the logic-reset level. Filtered faults are confirmed by persistence timers counted in clock cycles. Over-temperature and reference-too-low act on the next clock edge.

Top module: `drv_supervisor`

## Requirements
- R1: While `rst` is high, or after it, `state_o` is 0 (power-on reset) and `sw_en_o` is 0. From state 0, the first clock edge that samples `vcc_rst_i` low moves the block to state 1 (start, waiting for supply).
- R2: In state 1 with `vcc_on_i` high and no stop or latch condition, the block moves to state 2 (running). `sw_en_o` is 1 exactly while `state_o` is 2.
- R3: In state 2, `vcc_off_i` sampled high on `VOFF_CYC` consecutive edges returns the block to state 1 on the following edge. A shorter burst has no effect.
- R4: `ovp_over_i` sampled high on `OVP_CYC` consecutive edges forces state 3 (stop) on the next edge. Stop holds until `ovp_clear_i` has been sampled high while `ovp_over_i` is low. A burst shorter than `OVP_CYC` has no effect.
- R5: `uvp_i` sampled high on `UVP_CYC` consecutive edges forces state 3. That cause clears on the first edge that samples `uvp_i` low.
- R6: `otp_i` or `ref_low_i` high forces state 3 on the next edge. Leaving state 3 for state 2 needs every stop cause clear and `vcc_on_i` high.
- R7: A pulse is an edge with `drv_end_i` high. `WS_N` consecutive pulses with `wshort_i` high force state 4 (latched). A pulse with `wshort_i` low resets the run count to zero.
- R8: `cs2_open_i` high in state 1, 2 or 3 forces state 4 on the next edge.
- R9: State 4 is left only through `vcc_rst_i` high, which goes to state 0. No other input has an effect in state 4.
- R10: Priority on a single edge: `vcc_rst_i` over latch causes, latch causes over stop causes, and stop causes over running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_on_i | input | 1 | Supply above turn-on threshold |
| vcc_off_i | input | 1 | Supply below turn-off threshold |
| vcc_rst_i | input | 1 | Supply below logic-reset level |
| ovp_over_i | input | 1 | Output sense above upper overvoltage threshold |
| ovp_clear_i | input | 1 | Output sense below lower overvoltage threshold |
| uvp_i | input | 1 | Output sense below undervoltage threshold (open divider) |
| otp_i | input | 1 | Die over-temperature |
| wshort_i | input | 1 | Winding-short comparator fired in the current pulse |
| drv_end_i | input | 1 | One-cycle strobe at the end of each switching pulse |
| cs2_open_i | input | 1 | Off-time current-sense pin open |
| ref_low_i | input | 1 | Thermal foldback requests stop |
| sw_en_o | output | 1 | Switching enable (registered) |
| state_o | output | 3 | 0 reset, 1 start, 2 running, 3 stop, 4 latched |

## Verification
A corrupted persistence count would show up as a stop or start transition arriving one or more cycles away from the `N+1`-th edge after a condition begins. The cycle-accurate model flags that on the exact cycle. A winding-short run count that fails to clear would latch the block on a pulse sequence that should leave it running, which is visible on `state_o` within one edge of the offending pulse. A stale latch or stop flag would keep `sw_en_o` low after release and would be seen on the first cycle where the model expects state 2.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
  typedef enum logic [2:0] {
    ST_POR   = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_STOP  = 3'd3,
    ST_LATCH = 3'd4
  } sup_state_e;
endpackage

// File: rtl/fault_timer.sv
// Persistence filter: flag sets after LIM consecutive sampled-high cycles,
// clears when the condition is low and the release input is high.
module fault_timer #(
  parameter int LIM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  input  logic rel_i,
  output logic flag_o
);
  localparam int CW = (LIM > 2) ? $clog2(LIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cond_i) begin
      if (cnt_q == LAST) flag_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      if (rel_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wshort_counter.sv
// Counts consecutive switching pulses on which the winding-short comparator fired.
module wshort_counter #(
  parameter int WS_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic hit_i,
  output logic trip_o
);
  localparam int CW = (WS_N > 1) ? $clog2(WS_N + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(WS_N - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (pulse_i) begin
      if (!hit_i)             run_q <= '0;
      else if (run_q != LAST) run_q <= run_q + 1'b1;
    end
  end

  assign trip_o = pulse_i & hit_i & (run_q == LAST);
endmodule

// File: rtl/drv_sup_fsm.sv
module drv_sup_fsm
  import drv_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_rst_i,
  input  logic       vcc_on_i,
  input  logic       uvlo_i,
  input  logic       stop_req_i,
  input  logic       latch_req_i,
  output sup_state_e state_o,
  output logic       sw_en_o
);
  sup_state_e st_q, st_d;
  logic       en_q;

  always_comb begin
    st_d = st_q;
    if (vcc_rst_i) begin
      st_d = ST_POR;
    end else begin
      case (st_q)
        ST_POR:   st_d = ST_START;
        ST_START: begin
          if (latch_req_i)   st_d = ST_LATCH;
          else if (vcc_on_i) st_d = stop_req_i ? ST_STOP : ST_RUN;
        end
        ST_RUN: begin
          if (latch_req_i)     st_d = ST_LATCH;
          else if (stop_req_i) st_d = ST_STOP;
          else if (uvlo_i)     st_d = ST_START;
        end
        ST_STOP: begin
          if (latch_req_i)                  st_d = ST_LATCH;
          else if (!stop_req_i && vcc_on_i) st_d = ST_RUN;
        end
        ST_LATCH: st_d = ST_LATCH;
        default:  st_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_POR;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= (st_d == ST_RUN);
    end
  end

  assign state_o = st_q;
  assign sw_en_o = en_q;
endmodule

// File: rtl/drv_supervisor.sv
module drv_supervisor
  import drv_sup_pkg::*;
#(
  parameter int VOFF_CYC = 2500,
  parameter int OVP_CYC  = 8250,
  parameter int UVP_CYC  = 8250,
  parameter int WS_N     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       vcc_rst_i,
  input  logic       ovp_over_i,
  input  logic       ovp_clear_i,
  input  logic       uvp_i,
  input  logic       otp_i,
  input  logic       wshort_i,
  input  logic       drv_end_i,
  input  logic       cs2_open_i,
  input  logic       ref_low_i,
  output logic       sw_en_o,
  output logic [2:0] state_o
);
  logic       uvlo_flag, ovp_flag, uvp_flag, ws_trip;
  logic       stop_req, latch_req;
  sup_state_e st;

  fault_timer #(.LIM(VOFF_CYC)) u_voff (
    .clk(clk), .rst(rst), .cond_i(vcc_off_i), .rel_i(1'b1), .flag_o(uvlo_flag));

  fault_timer #(.LIM(OVP_CYC)) u_ovp (
    .clk(clk), .rst(rst), .cond_i(ovp_over_i), .rel_i(ovp_clear_i), .flag_o(ovp_flag));

  fault_timer #(.LIM(UVP_CYC)) u_uvp (
    .clk(clk), .rst(rst), .cond_i(uvp_i), .rel_i(1'b1), .flag_o(uvp_flag));

  wshort_counter #(.WS_N(WS_N)) u_ws (
    .clk(clk), .rst(rst), .pulse_i(drv_end_i), .hit_i(wshort_i), .trip_o(ws_trip));

  assign stop_req  = ovp_flag | uvp_flag | otp_i | ref_low_i;
  assign latch_req = ws_trip | cs2_open_i;

  drv_sup_fsm u_fsm (
    .clk(clk), .rst(rst), .vcc_rst_i(vcc_rst_i), .vcc_on_i(vcc_on_i),
    .uvlo_i(uvlo_flag), .stop_req_i(stop_req), .latch_req_i(latch_req),
    .state_o(st), .sw_en_o(sw_en_o));

  assign state_o = st;
endmodule

// File: rtl/drv_supervisor_chk.sv
module drv_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       vcc_on_i,
  input logic       vcc_rst_i,
  input logic       otp_i,
  input logic       cs2_open_i,
  input logic       sw_en_o,
  input logic [2:0] state_o
);
  AST_RST_TO_POR: assert property (@(posedge clk) disable iff (rst)
    vcc_rst_i |=> (state_o == 3'd0)); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) && !vcc_rst_i |=> (state_o == 3'd4)); // R9
  AST_CS2_LATCH: assert property (@(posedge clk) disable iff (rst)
    cs2_open_i && !vcc_rst_i && (state_o != 3'd0) |=> (state_o == 3'd4)); // R8
  AST_OTP_OFF: assert property (@(posedge clk) disable iff (rst)
    otp_i |=> !sw_en_o); // R6
  AST_NO_RUN_LOW_VCC: assert property (@(posedge clk) disable iff (rst)
    (state_o != 3'd2) && !vcc_on_i |=> (state_o != 3'd2)); // R2
endmodule

bind drv_supervisor drv_supervisor_chk u_chk (.*);

// File: tb/drv_supervisor_bench.sv
module drv_supervisor_bench;
  localparam int VOFF = 8, OVPN = 12, UVPN = 10, WSN = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic vcc_on = 0, vcc_off = 0, vcc_rst = 1, ovp_over = 0, ovp_clear = 0;
  logic uvp = 0, otp = 0, wsh = 0, drv_end = 0, cs2 = 0, ref_low = 0;
  logic sw_en;
  logic [2:0] state;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit done = 0;

  drv_supervisor #(.VOFF_CYC(VOFF), .OVP_CYC(OVPN), .UVP_CYC(UVPN), .WS_N(WSN)) u_drv_supervisor (
    .clk(clk), .rst(rst), .vcc_on_i(vcc_on), .vcc_off_i(vcc_off), .vcc_rst_i(vcc_rst),
    .ovp_over_i(ovp_over), .ovp_clear_i(ovp_clear), .uvp_i(uvp), .otp_i(otp),
    .wshort_i(wsh), .drv_end_i(drv_end), .cs2_open_i(cs2), .ref_low_i(ref_low),
    .sw_en_o(sw_en), .state_o(state));

  always #2 clk = ~clk;

  // Behavioural reference model
  int m_st = 0, m_oc = 0, m_uc = 0, m_vc = 0, m_ws = 0;
  bit m_en = 0, m_of = 0, m_uf = 0, m_vf = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_en = 0; m_oc = 0; m_uc = 0; m_vc = 0; m_ws = 0;
      m_of = 0; m_uf = 0; m_vf = 0;
    end else begin
      bit lreq, sreq;
      lreq = cs2 || (drv_end && wsh && m_ws == WSN - 1);
      sreq = m_of || m_uf || otp || ref_low;
      if (vcc_rst) m_st = 0;
      else if (m_st == 0) m_st = 1;
      else if (m_st == 4) m_st = 4;
      else if (lreq) m_st = 4;
      else if (m_st == 1) begin if (vcc_on) m_st = sreq ? 3 : 2; end
      else if (m_st == 2) begin if (sreq) m_st = 3; else if (m_vf) m_st = 1; end
      else if (m_st == 3) begin if (!sreq && vcc_on) m_st = 2; end
      m_en = (m_st == 2);
      if (ovp_over) begin if (m_oc == OVPN - 1) m_of = 1; else m_oc++; end
      else begin m_oc = 0; if (ovp_clear) m_of = 0; end
      if (uvp) begin if (m_uc == UVPN - 1) m_uf = 1; else m_uc++; end
      else begin m_uc = 0; m_uf = 0; end
      if (vcc_off) begin if (m_vc == VOFF - 1) m_vf = 1; else m_vc++; end
      else begin m_vc = 0; m_vf = 0; end
      if (drv_end) m_ws = wsh ? ((m_ws < WSN - 1) ? m_ws + 1 : m_ws) : 0;
    end
  end

  always @(negedge clk) if (!done) begin
    compared++;
    if (state !== 3'(m_st) || sw_en !== m_en) begin
      mismatched++;
      $display("FAIL %s cycle compare: state=%0d en=%0b expected state=%0d en=%0b",
               tag, state, sw_en, m_st, m_en);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(logic [2:0] e, string req);
    compared++;
    if (state !== e || sw_en !== (e == 3'd2)) begin
      mismatched++;
      $display("FAIL %s state check: state=%0d en=%0b expected state=%0d en=%0b",
               req, state, sw_en, e, (e == 3'd2));
    end
  endtask

  task automatic pulse(logic hit);
    drv_end = 1; wsh = hit; step(1);
    drv_end = 0; wsh = 0; step(2);
  endtask

  initial begin
    step(3);
    expect_st(3'd0, "R1");
    rst = 0; step(3);
    expect_st(3'd0, "R1");
    vcc_rst = 0; step(1);
    expect_st(3'd1, "R1");
    tag = "R2"; step(3);
    expect_st(3'd1, "R2");
    vcc_on = 1; step(1);
    expect_st(3'd2, "R2");

    tag = "R3"; vcc_off = 1; step(VOFF - 1); vcc_off = 0; step(3);
    expect_st(3'd2, "R3");
    vcc_off = 1; vcc_on = 0; step(VOFF + 1);
    expect_st(3'd1, "R3");
    vcc_off = 0; step(2); vcc_on = 1; step(1);
    expect_st(3'd2, "R3");

    tag = "R4"; ovp_over = 1; step(OVPN - 1); ovp_over = 0; step(2);
    expect_st(3'd2, "R4");
    ovp_over = 1; step(OVPN + 1);
    expect_st(3'd3, "R4");
    ovp_over = 0; step(4);
    expect_st(3'd3, "R4");
    ovp_clear = 1; step(3);
    expect_st(3'd2, "R4");
    ovp_clear = 0;

    tag = "R5"; uvp = 1; step(UVPN + 1);
    expect_st(3'd3, "R5");
    uvp = 0; step(3);
    expect_st(3'd2, "R5");

    tag = "R6"; otp = 1; step(1);
    expect_st(3'd3, "R6");
    vcc_on = 0; otp = 0; step(3);
    expect_st(3'd3, "R6");
    vcc_on = 1; step(2);
    expect_st(3'd2, "R6");
    ref_low = 1; step(1);
    expect_st(3'd3, "R6");
    ref_low = 0; step(2);
    expect_st(3'd2, "R6");

    tag = "R7";
    for (int i = 0; i < WSN - 1; i++) pulse(1);
    pulse(0);
    for (int i = 0; i < WSN - 1; i++) pulse(1);
    expect_st(3'd2, "R7");
    pulse(1);
    expect_st(3'd4, "R7");

    tag = "R9"; step(5);
    expect_st(3'd4, "R9");
    vcc_rst = 1; step(1);
    expect_st(3'd0, "R9");
    vcc_rst = 0; step(2);
    expect_st(3'd2, "R9");

    tag = "R8"; cs2 = 1; step(1); cs2 = 0; step(1);
    expect_st(3'd4, "R8");
    vcc_rst = 1; step(1); vcc_rst = 0; step(2);
    expect_st(3'd2, "R8");

    tag = "R10"; otp = 1; step(2);
    expect_st(3'd3, "R10");
    cs2 = 1; step(1); cs2 = 0; otp = 0; step(3);
    expect_st(3'd4, "R10");
    vcc_rst = 1; cs2 = 1; step(1);
    expect_st(3'd0, "R10");
    vcc_rst = 0; cs2 = 0; step(2);
    expect_st(3'd2, "R10");
    otp = 1; ovp_over = 1; cs2 = 1; step(1);
    expect_st(3'd4, "R10");
    otp = 0; ovp_over = 0; cs2 = 0; step(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule